// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Aggregator

This block collects a set of external interrupt lines, by default thirty-two, and merges them onto two processor-facing request outputs: a normal request and a critical, machine-check style request. Each line has its own settings for active level, level or edge sensing, masking, and which of the two outputs it drives. Every input first passes through a two-flop synchroniser. The block then adjusts it for polarity and, for edge-sensed lines, detects the active transition.

Pending events are latched in a raw status register, and software acknowledges them by writing ones to that register. A masked view shows only the enabled pending lines. A vector register gives the number of the most urgent pending enabled line. The priority is fixed, and line 0 is the most urgent.

Software reaches the registers through a simple single-cycle port: a write strobe, a 3-bit register select, write data, and read data that follows the select combinationally.

Top module: `irq_hub`

## Requirements
- R1: After reset, the status and enable registers hold 0, the route and polarity registers hold all ones, the trigger register holds 0, both request outputs are low, and the vector reads all ones.
- R2: A change on an input line reaches the status register at the third rising clock edge after it is applied. The first two edges pass it through the two synchroniser flops.
- R3: For a line whose trigger bit is 0 (level), the status bit is set on every cycle in which the synchronised line is at its active level. Polarity bit 1 means active-high and 0 means active-low.
- R4: For a line whose trigger bit is 1 (edge), the status bit is set only on the cycle the synchronised line moves from inactive to active. A line that stays active does not set the bit again after it is cleared.
- R5: Writing to select 0 (status) clears each status bit written with 1 and leaves each bit written with 0 unchanged. A level line that is still active sets its bit again on the next cycle. An active edge detected in the same cycle as the clear is kept.
- R6: Select 5 reads status AND enable.
- R7: The normal output is the OR of the masked status bits whose route bit is 1. The critical output is the OR of those whose route bit is 0. Both outputs are registered, so they follow the status register by one cycle.
- R8: Select 6 reads the number of the lowest-numbered line that is pending and enabled, or all ones when there is none.
- R9: Line n occupies bit 31-n of the input bus and of every register, so line 0 is the most significant bit.
- R10: Selects 1 to 4 read back the enable, route, polarity and trigger registers as written. Writes to selects 5, 6 and 7 change nothing, and select 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register |
| srcIn | input | 32 | Interrupt lines, line n on bit 31-n |
| intOut | output | 1 | Normal interrupt request |
| critOut | output | 1 | Critical interrupt request |

## Verification
The assertions assume that the select is stable across each clock edge and that reset is applied at time zero, so the masked-view and vector checks compare read data with state that is settled. The bench changes select, data and lines only two nanoseconds after a rising edge, and it holds reset over the first cycles. Lines may toggle on any cycle, because the synchroniser absorbs their timing relative to the clock. The random phase therefore drives arbitrary patterns, including clears that land in the same cycle as new edges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT  = 3'd0,
    SEL_EN    = 3'd1,
    SEL_ROUTE = 3'd2,
    SEL_POL   = 3'd3,
    SEL_TRIG  = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_VEC   = 3'd6,
    SEL_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic clrStat;
    logic ldEn;
    logic ldRoute;
    logic ldPol;
    logic ldTrig;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strb,
  output regSel_e           rdSel
);
  always_comb begin
    rdSel = regSel_e'(addr);
    strb  = '0;
    if (wrEn) begin
      unique case (rdSel)
        SEL_STAT:  strb.clrStat = 1'b1;
        SEL_EN:    strb.ldEn    = 1'b1;
        SEL_ROUTE: strb.ldRoute = 1'b1;
        SEL_POL:   strb.ldPol   = 1'b1;
        SEL_TRIG:  strb.ldTrig  = 1'b1;
        default:   strb         = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strb,
  input  regSel_e         rdSel,
  input  logic [NSRC-1:0] wrData,
  input  logic [NSRC-1:0] srcIn,
  output logic [NSRC-1:0] rdData,
  output logic            intOut,
  output logic            critOut,
  output logic [NSRC-1:0] statusQ,
  output logic [NSRC-1:0] enableQ
);
  logic [NSRC-1:0] syncA, syncB, prevAct;
  logic [NSRC-1:0] routeQ, polQ, trigQ;
  logic [NSRC-1:0] activeLvl, setEdge, setLevel, statusNext;
  logic [NSRC-1:0] masked, clrMask, vecVal;

  assign clrMask = strb.clrStat ? wrData : '0;
  assign masked  = statusQ & enableQ;

  for (genvar b = 0; b < NSRC; b++) begin : g_src
    assign activeLvl[b]  = polQ[b] ? syncB[b] : ~syncB[b];
    assign setEdge[b]    = trigQ[b] & activeLvl[b] & ~prevAct[b];
    assign setLevel[b]   = ~trigQ[b] & activeLvl[b];
    assign statusNext[b] = (statusQ[b] & ~clrMask[b]) | setEdge[b]
                         | (setLevel[b] & ~clrMask[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevAct <= '0;
      statusQ <= '0;
      enableQ <= '0;
      routeQ  <= '1;
      polQ    <= '1;
      trigQ   <= '0;
      intOut  <= 1'b0;
      critOut <= 1'b0;
    end else begin
      syncA   <= srcIn;
      syncB   <= syncA;
      prevAct <= activeLvl;
      statusQ <= statusNext;
      if (strb.ldEn)    enableQ <= wrData;
      if (strb.ldRoute) routeQ  <= wrData;
      if (strb.ldPol)   polQ    <= wrData;
      if (strb.ldTrig)  trigQ   <= wrData;
      intOut  <= |(masked & routeQ);
      critOut <= |(masked & ~routeQ);
    end
  end

  // highest bit index wins: that is the lowest-numbered line
  always_comb begin
    vecVal = '1;
    for (int i = 0; i < NSRC; i++)
      if (masked[i]) vecVal = NSRC'(NSRC - 1 - i);
  end

  always_comb begin
    unique case (rdSel)
      SEL_STAT:  rdData = statusQ;
      SEL_EN:    rdData = enableQ;
      SEL_ROUTE: rdData = routeQ;
      SEL_POL:   rdData = polQ;
      SEL_TRIG:  rdData = trigQ;
      SEL_MASK:  rdData = masked;
      SEL_VEC:   rdData = vecVal;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [2:0]      addr,
  input  logic [NSRC-1:0] wrData,
  output logic [NSRC-1:0] rdData,
  input  logic [NSRC-1:0] srcIn,
  output logic            intOut,
  output logic            critOut
);
  ctlStrobe_t      strb;
  regSel_e         rdSel;
  logic [NSRC-1:0] statusQ, enableQ;

  irq_ctrl uCtrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  irq_datapath #(.NSRC(NSRC)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .wrData  (wrData),
    .srcIn   (srcIn),
    .rdData  (rdData),
    .intOut  (intOut),
    .critOut (critOut),
    .statusQ (statusQ),
    .enableQ (enableQ)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [2:0]      addr,
  input logic [NSRC-1:0] wrData,
  input logic [NSRC-1:0] rdData,
  input logic            intOut,
  input logic            critOut,
  input logic [NSRC-1:0] statusQ,
  input logic [NSRC-1:0] enableQ
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusQ == '0 && enableQ == '0 && !intOut && !critOut));

  // R5
  w1c_zero_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && wrData == '0) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R6
  masked_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd5) |-> ((rdData & ~enableQ) == '0 && (rdData & ~statusQ) == '0));

  // R7
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd5 && rdData == '0) |=> (!intOut && !critOut));

  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd6) |-> (rdData == '1 || rdData < NSRC));

  // R8
  vec_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd6 && (statusQ & enableQ) == '0) |-> (rdData == '1));

  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != 3'd1) |=> (enableQ == $past(enableQ)));
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .intOut  (intOut),
  .critOut (critOut),
  .statusQ (statusQ),
  .enableQ (enableQ)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] srcIn = '0;
  logic [31:0] rdData;
  logic        intOut, critOut;

  int nTests = 0;
  int nFail  = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .intOut(intOut), .critOut(critOut)
  );

  // behavioural reference, indexed by line number n (bit 31-n, R9)
  bit mS1[32], mS2[32], mPrev[32], mSt[32], mEn[32], mRoute[32], mPol[32], mTrig[32];
  bit mInt, mCrit;
  bit nSt[32], nPrev[32];

  function automatic logic [31:0] pack(input bit v[32]);
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++) r[31-n] = v[n];
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return pack(mSt);
      3'd1: return pack(mEn);
      3'd2: return pack(mRoute);
      3'd3: return pack(mPol);
      3'd4: return pack(mTrig);
      3'd5: return pack(mSt) & pack(mEn);
      3'd6: begin
        for (int n = 0; n < 32; n++) if (mSt[n] && mEn[n]) return 32'(n);
        return 32'hFFFF_FFFF;
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] a);
    case (a)
      3'd0: return "R5 status (R2 R3 R4 R9)";
      3'd5: return "R6 masked";
      3'd6: return "R8 vector";
      default: return "R10 readback";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < 32; n++) begin
        mS1[n] = 0; mS2[n] = 0; mPrev[n] = 0; mSt[n] = 0; mEn[n] = 0;
        mRoute[n] = 1; mPol[n] = 1; mTrig[n] = 0;
      end
      mInt = 0; mCrit = 0;
    end else begin
      mInt = 0; mCrit = 0;
      for (int n = 0; n < 32; n++)
        if (mSt[n] && mEn[n]) begin
          if (mRoute[n]) mInt = 1; else mCrit = 1;
        end
      for (int n = 0; n < 32; n++) begin
        bit act, clr;
        act = mPol[n] ? mS2[n] : !mS2[n];
        clr = wrEn && addr == 3'd0 && wrData[31-n];
        nSt[n] = (mSt[n] && !clr) || (mTrig[n] && act && !mPrev[n])
               || (!mTrig[n] && act && !clr);
        nPrev[n] = act;
      end
      for (int n = 0; n < 32; n++) begin
        mSt[n] = nSt[n]; mPrev[n] = nPrev[n];
        mS2[n] = mS1[n]; mS1[n] = srcIn[31-n];
        if (wrEn && addr == 3'd1) mEn[n]    = wrData[31-n];
        if (wrEn && addr == 3'd2) mRoute[n] = wrData[31-n];
        if (wrEn && addr == 3'd3) mPol[n]   = wrData[31-n];
        if (wrEn && addr == 3'd4) mTrig[n]  = wrData[31-n];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("[TB] FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(tagOf(addr), rdData, expRead(addr));
      chk("R7 intOut", 32'(intOut), 32'(mInt));
      chk("R7 critOut", 32'(critOut), 32'(mCrit));
    end
  end

  task automatic step(input bit w, input logic [2:0] a, input logic [31:0] d,
                      input logic [31:0] s);
    @(posedge clk);
    #2;
    wrEn = w; addr = a; wrData = d; srcIn = s;
  endtask

  task automatic idle(input int cycles);
    for (int k = 0; k < cycles; k++) step(1'b0, 3'(k), '0, srcIn);
  endtask

  initial begin
    // R1: reset values, checked while reset is held
    repeat (3) @(posedge clk);
    #2 addr = 3'd0; #1 chk("R1 status", rdData, 32'h0);
    addr = 3'd1; #1 chk("R1 enable", rdData, 32'h0);
    addr = 3'd2; #1 chk("R1 route", rdData, 32'hFFFF_FFFF);
    addr = 3'd3; #1 chk("R1 polarity", rdData, 32'hFFFF_FFFF);
    addr = 3'd4; #1 chk("R1 trigger", rdData, 32'h0);
    addr = 3'd6; #1 chk("R1 vector", rdData, 32'hFFFF_FFFF);
    chk("R1 outputs", 32'({intOut, critOut}), 32'h0);
    @(posedge clk); #2 rstN = 1'b1; running = 1'b1;

    // configure lines 0,3,7,31 (bits 31,28,24,0; R9)
    step(1'b1, 3'd1, 32'h9100_0001, '0);
    step(1'b1, 3'd2, 32'hEFFF_FFFF, '0);   // line 3 critical (R7)
    step(1'b1, 3'd3, 32'hFEFF_FFFF, '0);   // line 7 active-low (R3)
    step(1'b1, 3'd4, 32'h1000_0001, '0);   // lines 3 and 31 edge (R4)
    idle(8);
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0100_0000);  // deassert line 7, clear all
    idle(8);
    // level line 0: clear while held, re-set next cycle (R5)
    step(1'b0, 3'd6, '0, 32'h8100_0000);
    idle(6);
    step(1'b1, 3'd0, 32'h8000_0000, srcIn);
    idle(4);
    step(1'b0, 3'd0, '0, 32'h0100_0000);
    step(1'b1, 3'd0, 32'hFFFF_FFFF, srcIn);
    // edge lines 3 and 31: pulse, hold, clear, hold (R4)
    step(1'b0, 3'd5, '0, 32'h1100_0001);
    idle(6);
    step(1'b1, 3'd0, 32'h1000_0001, srcIn);
    idle(6);
    step(1'b0, 3'd6, '0, 32'h0100_0000);
    idle(4);
    // clears at every offset against a new edge (R5)
    for (int off = 0; off < 5; off++) begin
      step(1'b0, 3'd0, '0, 32'h0100_0001);
      for (int k = 0; k < off; k++) step(1'b0, 3'd0, '0, srcIn);
      step(1'b1, 3'd0, 32'h0000_0001, srcIn);
      idle(4);
      step(1'b0, 3'd0, '0, 32'h0100_0000);
      idle(3);
    end
    // random patterns
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] s;
      s = srcIn ^ ($urandom & $urandom & $urandom);
      if (($urandom % 8) == 0) step(1'b1, 3'($urandom), $urandom, s);
      else step(1'b0, 3'($urandom), '0, s);
    end
    idle(8);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("[TB] FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule